// File: doc/BRIEF.md
# Width-Configurable Pipelined Burst Bus Master

This block is the master side of a split-transaction bus. It accepts one access request at a time from a processor-side port. Each request becomes an address tenure on the bus and, unless it carries no data, a data tenure. The width of the data path is either 32 or 64 bits. A strap input selects it while reset is held, and the width then stays fixed until the next reset. The block chooses the number of data beats from the kind of request and the selected width. It forms byte lanes for sub-word accesses. It refuses requests that it cannot place on the bus.

The address and data phases are decoupled. Once an address has been acknowledged, it waits in a one-entry slot until the data path is free. This lets the next address tenure be offered and acknowledged while the current data tenure is still moving beats. Data tenures complete strictly in the order in which their addresses were acknowledged. The slave inserts wait states by withholding the per-beat data acknowledge.

Top module: `wide_burst_master`

## Requirements
- R1: The width strap is sampled on every clock edge while `rst` is high (1 = 64-bit bus, 0 = 32-bit bus). Changes on the strap after reset have no effect until the next reset.
- R2: The beat count is set by the request kind (`req_kind` 0 = single, 1 = double, 2 = line, 3 = address-only). Single moves 1 beat and double moves 2. Line moves 32 bytes, which is 8 beats on a 32-bit bus and 4 beats on a 64-bit bus. Address-only moves no beats.
- R3: Bit i of `a_lanes` enables byte i of the bus word. For a single access, the enabled lanes are the `req_size` bytes starting at the address offset within the bus word (`req_addr[1:0]` on 32-bit, `req_addr[2:0]` on 64-bit). A line enables all lanes of the configured width, and a double enables lanes 3..0.
- R4: Some requests are flagged on `req_err` in the cycle they are accepted and never produce an address tenure. These are: a single whose bytes cross the bus word, and a single whose size is not 1, 2, 3 or 4 (or 8 on a 64-bit bus). A double on a 64-bit bus or not 8-byte aligned is also flagged. So is a line that is not 32-byte aligned.
- R5: An address-only request gets an address tenure with all lanes off, and it produces no data beats.
- R6: While `a_valid` is high and `a_ack` is low, the address tenure holds, with address and lanes unchanged.
- R7: Only one acknowledged address may wait behind the active data tenure. A data-carrying address is not offered while that slot is full, and `req_ready` stays low while an address is held.
- R8: Data tenures run in address-acknowledge order. A waiting tenure starts on the edge at which the previous one completes its last beat.
- R9: A beat completes only on a cycle with `d_ack` high. The beat address starts at the request address and advances by the bus width (4 or 8 bytes) after each completed beat, without wrapping. `d_last` marks the final beat.
- R10: A double on a 32-bit bus carries 64 bits. Its first beat uses the request address (the lower word) and its second beat uses that address plus 4.
- R11: On read beats, `rsp_valid` goes high in the `d_ack` cycle with `rsp_rdata` = `d_rdata` and `rsp_last` = `d_last`. On write beats, `cpu_wtake` goes high in the `d_ack` cycle and `d_wdata` mirrors `cpu_wdata`.
- R12: After reset, `req_ready` is 1 and `a_valid` and `d_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_strap | input | 1 | Bus width select, sampled during reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 single, 1 double, 2 line, 3 address-only |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 4 | Byte count of a single access |
| req_err | output | 1 | Request refused in this cycle |
| cpu_wdata | input | 64 | Write data for the current beat |
| cpu_wtake | output | 1 | Write beat consumed |
| rsp_valid | output | 1 | Read beat returned |
| rsp_rdata | output | 64 | Read beat data |
| rsp_last | output | 1 | Returned beat is the last |
| a_valid | output | 1 | Address tenure active |
| a_addr | output | 32 | Tenure address |
| a_kind | output | 2 | Tenure kind, same code as `req_kind` |
| a_write | output | 1 | Tenure direction |
| a_lanes | output | 8 | Byte enables |
| a_ack | input | 1 | Address acknowledge from slave |
| d_active | output | 1 | Data tenure active |
| d_addr | output | 32 | Current beat address |
| d_write | output | 1 | Data tenure direction |
| d_last | output | 1 | Current beat is the last |
| d_wdata | output | 64 | Write data on the bus |
| d_rdata | input | 64 | Read data from the bus |
| d_ack | input | 1 | Per-beat data acknowledge |

## Verification
Some rules can be checked on every cycle. These are: an unacknowledged address tenure holds steady, and a data beat without acknowledge holds its address. The beat address steps by the configured width, and lanes stay inside a 32-bit bus. Address-only tenures carry no lanes, refused requests raise no address tenure, and the sampled width does not move outside reset. Other behaviour needs the bench's scenarios. That covers the beat counts and lane patterns for each kind and width, and the refusal of each illegal case. It also covers ordering when an address is acknowledged under an active burst, the blocking of a third address, and the strap being ignored after reset.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
    localparam int ADDR_W     = 32;
    localparam int MAX_DATA_W = 64;
    localparam int LANES      = MAX_DATA_W / 8;
    localparam int LINE_BYTES = 32;
    localparam int SIZE_W     = 4;
    localparam int BEAT_W     = $clog2(LINE_BYTES / 4) + 1;

    typedef enum logic [1:0] {
        XK_SINGLE = 2'd0,
        XK_DOUBLE = 2'd1,
        XK_LINE   = 2'd2,
        XK_ADDR   = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [BEAT_W-1:0] beats;
    } tenure_t;

    function automatic logic [BEAT_W-1:0] line_beats(input logic wide);
        return wide ? BEAT_W'(LINE_BYTES / LANES) : BEAT_W'(LINE_BYTES / (LANES / 2));
    endfunction

    function automatic logic [ADDR_W-1:0] beat_step(input logic wide);
        return wide ? ADDR_W'(LANES) : ADDR_W'(LANES / 2);
    endfunction
endpackage

// File: rtl/wbm_lane_gen.sv
module wbm_lane_gen
    import wbm_pkg::*;
(
    input  logic              wide,
    input  xfer_kind_e        kind,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  lanes,
    output logic [BEAT_W-1:0] beats,
    output logic              bad
);
    logic [2:0]       off;
    logic [4:0]       bus_bytes;
    logic [4:0]       end_pos;
    logic             size_ok;
    logic [LANES:0]   mask_w;
    logic [LANES-1:0] sub_lanes;

    always_comb begin
        off       = wide ? addr[2:0] : {1'b0, addr[1:0]};
        bus_bytes = wide ? 5'd8 : 5'd4;
        end_pos   = {2'b00, off} + {1'b0, size};
        size_ok   = (size >= 4'd1 && size <= 4'd4) || (wide && size == 4'd8);
        mask_w    = ({{LANES{1'b0}}, 1'b1} << size) - 1'b1;
        sub_lanes = mask_w[LANES-1:0] << off;
        lanes     = '0;
        beats     = '0;
        bad       = 1'b0;
        unique case (kind)
            XK_SINGLE: begin
                lanes = sub_lanes;
                beats = BEAT_W'(1);
                bad   = !size_ok || (end_pos > bus_bytes);
            end
            XK_DOUBLE: begin
                lanes = LANES'(8'h0F);
                beats = BEAT_W'(2);
                bad   = wide || (addr[2:0] != 3'd0);
            end
            XK_LINE: begin
                lanes = wide ? {LANES{1'b1}} : LANES'(8'h0F);
                beats = line_beats(wide);
                bad   = (addr[4:0] != 5'd0);
            end
            XK_ADDR: begin
                lanes = '0;
                beats = '0;
                bad   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wbm_addr_stage.sv
module wbm_addr_stage
    import wbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  xfer_kind_e        in_kind,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_lanes,
    input  logic [BEAT_W-1:0] in_beats,
    input  logic              room,
    input  logic              a_ack,
    output logic              busy,
    output logic              a_valid,
    output logic [ADDR_W-1:0] a_addr,
    output xfer_kind_e        a_kind,
    output logic              a_write,
    output logic [LANES-1:0]  a_lanes,
    output logic              hand_valid,
    output tenure_t           hand
);
    logic [BEAT_W-1:0] beats_q;
    logic              fire;

    assign a_valid    = busy && ((beats_q == '0) || room);
    assign fire       = a_valid && a_ack;
    assign hand_valid = fire && (beats_q != '0);
    assign hand       = '{addr: a_addr, write: a_write, beats: beats_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (fire) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_addr  <= '0;
            a_kind  <= XK_SINGLE;
            a_write <= 1'b0;
            a_lanes <= '0;
            beats_q <= '0;
        end else if (accept && !busy) begin
            a_addr  <= in_addr;
            a_kind  <= in_kind;
            a_write <= in_write;
            a_lanes <= in_lanes;
            beats_q <= in_beats;
        end
    end
endmodule

// File: rtl/wbm_data_stage.sv
module wbm_data_stage
    import wbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              hand_valid,
    input  tenure_t           hand,
    input  logic              d_ack,
    output logic              room,
    output logic              d_active,
    output logic [ADDR_W-1:0] d_addr,
    output logic              d_write,
    output logic              d_last
);
    tenure_t           pend_q;
    logic              pend_v;
    logic [BEAT_W-1:0] left_q;
    logic              beat_done;
    logic              finish;
    logic              take;

    assign room      = !pend_v;
    assign d_last    = d_active && (left_q == BEAT_W'(1));
    assign beat_done = d_active && d_ack;
    assign finish    = beat_done && d_last;
    assign take      = pend_v && (!d_active || finish);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_q   <= '0;
            d_active <= 1'b0;
            d_addr   <= '0;
            d_write  <= 1'b0;
            left_q   <= '0;
        end else begin
            if (hand_valid) begin
                pend_v <= 1'b1;
                pend_q <= hand;
            end else if (take) begin
                pend_v <= 1'b0;
            end

            if (take) begin
                d_active <= 1'b1;
                d_addr   <= pend_q.addr;
                d_write  <= pend_q.write;
                left_q   <= pend_q.beats;
            end else if (beat_done) begin
                d_active <= !finish;
                d_addr   <= d_addr + beat_step(wide);
                left_q   <= left_q - BEAT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wide_burst_master.sv
module wide_burst_master
    import wbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wide_strap,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_kind,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [SIZE_W-1:0]     req_size,
    output logic                  req_err,
    input  logic [MAX_DATA_W-1:0] cpu_wdata,
    output logic                  cpu_wtake,
    output logic                  rsp_valid,
    output logic [MAX_DATA_W-1:0] rsp_rdata,
    output logic                  rsp_last,
    output logic                  a_valid,
    output logic [ADDR_W-1:0]     a_addr,
    output logic [1:0]            a_kind,
    output logic                  a_write,
    output logic [LANES-1:0]      a_lanes,
    input  logic                  a_ack,
    output logic                  d_active,
    output logic [ADDR_W-1:0]     d_addr,
    output logic                  d_write,
    output logic                  d_last,
    output logic [MAX_DATA_W-1:0] d_wdata,
    input  logic [MAX_DATA_W-1:0] d_rdata,
    input  logic                  d_ack
);
    logic              wide_q;
    logic [LANES-1:0]  gen_lanes;
    logic [BEAT_W-1:0] gen_beats;
    logic              gen_bad;
    logic              busy;
    logic              accept;
    logic              room;
    logic              hand_valid;
    tenure_t           hand;
    xfer_kind_e        kind_in;
    xfer_kind_e        kind_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q <= wide_strap;
        end
    end

    assign kind_in   = xfer_kind_e'(req_kind);
    assign req_ready = !busy;
    assign req_err   = req_valid && !busy && gen_bad;
    assign accept    = req_valid && !busy && !gen_bad;
    assign a_kind    = kind_out;

    wbm_lane_gen i_lane_gen (
        .wide  (wide_q),
        .kind  (kind_in),
        .size  (req_size),
        .addr  (req_addr),
        .lanes (gen_lanes),
        .beats (gen_beats),
        .bad   (gen_bad)
    );

    wbm_addr_stage i_addr_stage (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .in_kind    (kind_in),
        .in_write   (req_write),
        .in_addr    (req_addr),
        .in_lanes   (gen_lanes),
        .in_beats   (gen_beats),
        .room       (room),
        .a_ack      (a_ack),
        .busy       (busy),
        .a_valid    (a_valid),
        .a_addr     (a_addr),
        .a_kind     (kind_out),
        .a_write    (a_write),
        .a_lanes    (a_lanes),
        .hand_valid (hand_valid),
        .hand       (hand)
    );

    wbm_data_stage i_data_stage (
        .clk        (clk),
        .rst        (rst),
        .wide       (wide_q),
        .hand_valid (hand_valid),
        .hand       (hand),
        .d_ack      (d_ack),
        .room       (room),
        .d_active   (d_active),
        .d_addr     (d_addr),
        .d_write    (d_write),
        .d_last     (d_last)
    );

    assign d_wdata   = cpu_wdata;
    assign cpu_wtake = d_active && d_write && d_ack;
    assign rsp_valid = d_active && !d_write && d_ack;
    assign rsp_rdata = d_rdata;
    assign rsp_last  = d_last;
endmodule

// File: rtl/wbm_checker.sv
module wbm_checker
    import wbm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wide_q,
    input logic              req_err,
    input logic              a_valid,
    input logic              a_ack,
    input logic [ADDR_W-1:0] a_addr,
    input logic [1:0]        a_kind,
    input logic [LANES-1:0]  a_lanes,
    input logic              d_active,
    input logic              d_ack,
    input logic              d_last,
    input logic [ADDR_W-1:0] d_addr
);
    assert_strap_fixed_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(wide_q));

    assert_narrow_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (a_valid && !wide_q) |-> (a_lanes[LANES-1:LANES/2] == '0));

    assert_refused_silent_R4: assert property (@(posedge clk) disable iff (rst)
        req_err |=> !a_valid);

    assert_addr_only_no_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_kind == XK_ADDR) |-> (a_lanes == '0));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (a_valid && !a_ack) |=> (a_valid && $stable(a_addr) && $stable(a_lanes)));

    assert_beat_wait_R9: assert property (@(posedge clk) disable iff (rst)
        (d_active && !d_ack) |=> (d_active && $stable(d_addr)));

    assert_beat_step_R9: assert property (@(posedge clk) disable iff (rst)
        (d_active && d_ack && !d_last) |=>
            (d_active && d_addr == $past(d_addr) + (wide_q ? 32'd8 : 32'd4)));
endmodule

bind wide_burst_master wbm_checker u_wbm_checker (
    .clk      (clk),
    .rst      (rst),
    .wide_q   (wide_q),
    .req_err  (req_err),
    .a_valid  (a_valid),
    .a_ack    (a_ack),
    .a_addr   (a_addr),
    .a_kind   (a_kind),
    .a_lanes  (a_lanes),
    .d_active (d_active),
    .d_ack    (d_ack),
    .d_last   (d_last),
    .d_addr   (d_addr)
);

// File: tb/test_wide_burst_master.sv
module test_wide_burst_master;
    logic        clk = 1'b0;
    logic        rst, wide_strap, req_valid, req_ready, req_write, req_err;
    logic [1:0]  req_kind, a_kind;
    logic [31:0] req_addr, a_addr, d_addr;
    logic [3:0]  req_size;
    logic [63:0] cpu_wdata, rsp_rdata, d_wdata, d_rdata;
    logic        cpu_wtake, rsp_valid, rsp_last, a_valid, a_write, a_ack;
    logic [7:0]  a_lanes;
    logic        d_active, d_write, d_last, d_ack;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    wide_burst_master i_wide_burst_master (.*);

    // {wide, kind, size, addr, err, lanes, beats}
    localparam logic [51:0] VECS [16] = '{
        {1'b0, 2'd0, 4'd1, 32'h0000_0003, 1'b0, 8'h08, 4'd1},
        {1'b0, 2'd0, 4'd2, 32'h0000_0002, 1'b0, 8'h0C, 4'd1},
        {1'b0, 2'd0, 4'd3, 32'h0000_0011, 1'b0, 8'h0E, 4'd1},
        {1'b0, 2'd0, 4'd4, 32'h0000_0020, 1'b0, 8'h0F, 4'd1},
        {1'b0, 2'd0, 4'd2, 32'h0000_0003, 1'b1, 8'h00, 4'd0},
        {1'b0, 2'd0, 4'd8, 32'h0000_0000, 1'b1, 8'h00, 4'd0},
        {1'b0, 2'd1, 4'd0, 32'h0000_0010, 1'b0, 8'h0F, 4'd2},
        {1'b0, 2'd2, 4'd0, 32'h0000_0040, 1'b0, 8'h0F, 4'd8},
        {1'b1, 2'd0, 4'd8, 32'h0000_0008, 1'b0, 8'hFF, 4'd1},
        {1'b1, 2'd0, 4'd3, 32'h0000_0005, 1'b0, 8'hE0, 4'd1},
        {1'b1, 2'd1, 4'd0, 32'h0000_0000, 1'b1, 8'h00, 4'd0},
        {1'b1, 2'd2, 4'd0, 32'h0000_0020, 1'b0, 8'hFF, 4'd4},
        {1'b1, 2'd2, 4'd0, 32'h0000_0024, 1'b1, 8'h00, 4'd0},
        {1'b0, 2'd3, 4'd0, 32'h0000_0100, 1'b0, 8'h00, 4'd0},
        {1'b1, 2'd0, 4'd4, 32'h0000_0006, 1'b1, 8'h00, 4'd0},
        {1'b1, 2'd0, 4'd5, 32'h0000_0000, 1'b1, 8'h00, 4'd0}
    };

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic w);
        @(negedge clk);
        rst = 1'b1; wide_strap = w; req_valid = 1'b0; req_kind = 2'd0; req_write = 1'b0;
        req_addr = '0; req_size = '0; cpu_wdata = '0; d_rdata = '0; a_ack = 1'b0; d_ack = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drives a request at a falling edge; returns at the next falling edge with req_valid low.
    task automatic issue(input logic [1:0] k, input logic wr, input logic [31:0] ad, input logic [3:0] sz);
        req_valid = 1'b1; req_kind = k; req_write = wr; req_addr = ad; req_size = sz;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    int nb, nlast;
    logic [31:0] first_a, last_a;

    // Runs data beats for n cycles with d_ack held high, collecting beat statistics.
    task automatic collect(input int n);
        nb = 0; nlast = 0; first_a = '0; last_a = '0;
        d_ack = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            if (d_active) begin
                if (nb == 0) first_a = d_addr;
                last_a = d_addr;
                nb++;
                if (rsp_last && rsp_valid) nlast++;
            end
            @(negedge clk);
        end
        d_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        // R12: reset state
        do_reset(1'b0);
        #1;
        chk(req_ready === 1'b1, "R12 req_ready", req_ready, 1);
        chk(a_valid === 1'b0, "R12 a_valid", a_valid, 0);
        chk(d_active === 1'b0, "R12 d_active", d_active, 0);

        // Table walk: R2 R3 R4 R5 R9 R10
        for (int v = 0; v < 16; v++) begin
            logic [51:0] e;
            logic [31:0] ad;
            logic [3:0]  eb;
            e  = VECS[v];
            ad = e[44:13];
            eb = e[3:0];
            do_reset(e[51]);
            req_valid = 1'b1; req_kind = e[50:49]; req_write = 1'b0; req_addr = ad; req_size = e[48:45];
            #1;
            chk(req_err === e[12], "R4 req_err", req_err, e[12]);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(a_valid === !e[12], "R4 a_valid after request", a_valid, !e[12]);
            if (!e[12]) begin
                chk(a_lanes === e[11:4], "R3 lanes", a_lanes, e[11:4]);
                chk(a_addr === ad, "R6 address", a_addr, ad);
            end
            a_ack = 1'b1;
            @(posedge clk);
            @(negedge clk);
            a_ack = 1'b0;
            collect(12);
            chk(nb == int'(eb), "R2 R5 beat count", nb, eb);
            if (eb != 0) begin
                chk(first_a === ad, "R10 first beat address", first_a, ad);
                chk(last_a === ad + (32'(eb) - 1) * (e[51] ? 32'd8 : 32'd4), "R9 last beat address",
                    last_a, ad + (32'(eb) - 1) * (e[51] ? 32'd8 : 32'd4));
                chk(nlast == 1, "R11 rsp_last once", nlast, 1);
            end
        end

        // R1: strap moved after reset has no effect
        do_reset(1'b0);
        wide_strap = 1'b1;
        issue(2'd2, 1'b0, 32'h80, 4'd0);
        #1;
        chk(a_lanes === 8'h0F, "R1 lanes stay narrow", a_lanes, 8'h0F);
        a_ack = 1'b1; @(posedge clk); @(negedge clk); a_ack = 1'b0;
        collect(14);
        chk(nb == 8, "R1 beats stay narrow", nb, 8);

        // R9: wait states
        do_reset(1'b1);
        issue(2'd2, 1'b0, 32'h40, 4'd0);
        a_ack = 1'b1; @(posedge clk); @(negedge clk); a_ack = 1'b0;
        begin
            int cnt, bad_hold;
            logic [31:0] hold_a;
            logic held;
            cnt = 0; bad_hold = 0; held = 1'b0; hold_a = '0;
            for (int i = 0; i < 20; i++) begin
                d_ack = (i % 2) == 1;
                #1;
                if (d_active) begin
                    if (held && d_addr !== hold_a) bad_hold++;
                    held = !d_ack; hold_a = d_addr;
                    if (d_ack) cnt++;
                end
                @(negedge clk);
            end
            d_ack = 1'b0;
            chk(cnt == 4, "R9 beats with wait states", cnt, 4);
            chk(bad_hold == 0, "R9 address held without ack", bad_hold, 0);
        end

        // R11: write double on narrow bus
        do_reset(1'b0);
        cpu_wdata = 64'hA5A5_0000_1234_5678;
        issue(2'd1, 1'b1, 32'h18, 4'd0);
        a_ack = 1'b1; @(posedge clk); @(negedge clk); a_ack = 1'b0;
        begin
            int takes, rsps, badw;
            takes = 0; rsps = 0; badw = 0;
            d_ack = 1'b1;
            for (int i = 0; i < 8; i++) begin
                #1;
                if (cpu_wtake) takes++;
                if (rsp_valid) rsps++;
                if (d_wdata !== cpu_wdata) badw++;
                @(negedge clk);
            end
            d_ack = 1'b0;
            chk(takes == 2, "R11 write beats taken", takes, 2);
            chk(rsps == 0, "R11 no read response on write", rsps, 0);
            chk(badw == 0, "R11 write data mirrored", badw, 0);
        end

        // R7 R8: overlap and ordering
        do_reset(1'b0);
        issue(2'd2, 1'b0, 32'h0, 4'd0);
        a_ack = 1'b1; @(posedge clk); @(negedge clk); a_ack = 1'b0;
        @(posedge clk); @(negedge clk);
        #1;
        chk(d_active === 1'b1, "R8 first tenure active", d_active, 1);
        issue(2'd0, 1'b1, 32'h200, 4'd4);
        #1;
        chk(a_valid === 1'b1, "R7 address offered under data tenure", a_valid, 1);
        a_ack = 1'b1; @(posedge clk); @(negedge clk); a_ack = 1'b0;
        issue(2'd0, 1'b0, 32'h300, 4'd4);
        #1;
        chk(a_valid === 1'b0, "R7 third address blocked", a_valid, 0);
        chk(req_ready === 1'b0, "R7 req_ready low while held", req_ready, 0);
        @(negedge clk);
        a_ack = 1'b1;
        begin
            logic [31:0] seq [16];
            int n, wt;
            n = 0; wt = 0;
            for (int i = 0; i < 16; i++) seq[i] = '1;
            d_ack = 1'b1;
            for (int i = 0; i < 24; i++) begin
                #1;
                if (d_active && n < 16) begin
                    seq[n] = d_addr;
                    if (cpu_wtake) wt++;
                    n++;
                end
                @(negedge clk);
            end
            d_ack = 1'b0; a_ack = 1'b0;
            chk(n == 10, "R8 total beats", n, 10);
            chk(seq[7] === 32'h1C, "R8 line ends first", seq[7], 32'h1C);
            chk(seq[8] === 32'h200, "R8 second tenure next", seq[8], 32'h200);
            chk(seq[9] === 32'h300, "R8 third tenure last", seq[9], 32'h300);
            chk(wt == 1, "R11 write beat in order", wt, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule